// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block collects eight interrupt request lines and presents the most urgent one to a processor as an 8-bit vector. Software sets it up through a two-address register port. A write to the low address that has bit 4 set starts configuration. The next writes to the high address are then taken in a fixed order: the vector base, an optional cascade word, and an optional mode word. Once configuration is complete, high-address writes set the interrupt mask. Low-address writes that have bit 4 clear are commands. They end service of an interrupt, switch special mask mode, or choose which status register a low-address read returns.

Requests are latched on a rising edge or followed as a level. A request that is pending and not masked competes under fixed priority, where input 0 is the most urgent. It is offered only if it outranks every input already in service. The vector leaves the block on a valid/ready port. The processor raises `vec_ready` to accept the vector, and a transfer happens on any cycle where `vec_valid` and `vec_ready` are both high. `vec_valid` may drop, and `vec_data` may change, before a transfer takes place, because a newer or more urgent request, or a mask change, can replace the offer. Holding `vec_ready` high simply accepts each offer as it appears. An accepted vector moves its input from the request register to the in-service register. In automatic end-of-interrupt mode the in-service register is left unchanged.

The cascade word is stored and made visible on a pin, but the block has no bus for chaining controllers.

Top module: `pic8_core`

## Requirements
- R1: After reset, a low-address read returns the request register (0x00), a high-address read returns the mask (0x00), `vec_valid` is 0 and `cascade_word` is 0x00. The block starts in edge mode with configuration complete.
- R2: A low-address write with bit 4 set clears the mask, the request register and the in-service register. It also clears special mask mode and selects the request register for low-address reads.
- R3: After that write, the first high-address write sets the vector base. A second write sets the cascade word, but only when bit 1 of the start word was 0. A further write is the mode word, but only when bit 0 of the start word was 1. Every later high-address write loads the mask.
- R4: The offered vector is bits 7:3 of the vector base followed by the 3-bit input number.
- R5: Input 0 has the highest priority. `vec_valid` is 1 only when the winning unmasked pending input has a lower number than every input counted as in service.
- R6: A mask bit of 1 keeps its input from being offered, but the request stays visible in the request register.
- R7: In edge mode (bit 3 of the start word is 0), a request bit is set on a rising input. It stays set after the input falls. It is not set again while the input stays high after being accepted.
- R8: In level mode (bit 3 of the start word is 1), a request bit follows its input.
- R9: A vector transfer clears that input's request bit and sets its in-service bit.
- R10: A low-address command write with bits 4:3 = 00 and bits 6:5 = 01 clears the lowest-numbered in-service bit.
- R11: A low-address command write with bits 4:3 = 00 and bits 6:5 = 11 clears the in-service bit selected by bits 2:0.
- R12: When bit 1 of the mode word is 1, a transfer leaves the in-service register unchanged.
- R13: A low-address write with bit 4 = 0 and bit 3 = 1 selects the low-address read source. Bits 1:0 = 11 select the in-service register, and 10 select the request register.
- R14: The same kind of write with bits 6:5 = 11 enters special mask mode, and with 10 leaves it. In special mask mode, masked in-service bits do not block lower-priority inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register address (0 = command/status, 1 = data/mask) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current `addr` |
| irq_in | input | 8 | Interrupt request lines |
| vec_valid | output | 1 | A vector is offered (interrupt to processor) |
| vec_ready | input | 1 | Processor accepts the offered vector |
| vec_data | output | 8 | Offered vector |
| cascade_word | output | 8 | Stored cascade configuration word |

## Verification
Status readback has no delay, and the vector port is driven combinationally from the registered state, so a wrong request, in-service or mask bit shows up in the first cycle after the write or edge that caused it. A stale in-service bit appears as `vec_valid` staying low for a lower-priority input. A lost request appears as a missing offer. A configuration sequencer that falls out of step shows up one write later, when a mask write reads back as something else or the vector base is wrong.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  typedef enum logic [1:0] {
    ST_BASE = 2'd0,
    ST_CASC = 2'd1,
    ST_MODE = 2'd2,
    ST_RUN  = 2'd3
  } cfg_state_e;
endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg #(
  parameter int NUM_IN = 8,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [NUM_IN-1:0] wdata,
  output logic              restart,
  output logic              cfg_run,
  output logic              level_mode,
  output logic              auto_eoi,
  output logic [NUM_IN-1:IDX_W] vec_base,
  output logic [NUM_IN-1:0] mask,
  output logic [NUM_IN-1:0] cascade,
  output logic              spec_mask,
  output logic              show_isr,
  output logic              eoi_top,
  output logic              eoi_sel,
  output logic [IDX_W-1:0]  eoi_idx
);
  import pic8_pkg::*;

  cfg_state_e st_q;
  logic single_q, need_mode_q;
  logic wr_lo, wr_hi, sel_cmd, ctl_cmd;

  always_comb begin
    wr_lo   = wr_en & ~addr;
    wr_hi   = wr_en & addr;
    restart = wr_lo & wdata[4];
    sel_cmd = wr_lo & ~wdata[4] & wdata[3];
    ctl_cmd = wr_lo & ~wdata[4] & ~wdata[3];
    eoi_top = ctl_cmd & (wdata[6:5] == 2'b01);
    eoi_sel = ctl_cmd & (wdata[6:5] == 2'b11);
    eoi_idx = wdata[IDX_W-1:0];
    cfg_run = (st_q == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_RUN;
      single_q    <= 1'b1;
      need_mode_q <= 1'b0;
      level_mode  <= 1'b0;
      auto_eoi    <= 1'b0;
      vec_base    <= '0;
      mask        <= '0;
      cascade     <= '0;
      spec_mask   <= 1'b0;
      show_isr    <= 1'b0;
    end else if (restart) begin
      level_mode  <= wdata[3];
      single_q    <= wdata[1];
      need_mode_q <= wdata[0];
      auto_eoi    <= 1'b0;
      mask        <= '0;
      spec_mask   <= 1'b0;
      show_isr    <= 1'b0;
      st_q        <= ST_BASE;
    end else if (wr_hi) begin
      unique case (st_q)
        ST_BASE: begin
          vec_base <= wdata[NUM_IN-1:IDX_W];
          if (!single_q)       st_q <= ST_CASC;
          else if (need_mode_q) st_q <= ST_MODE;
          else                 st_q <= ST_RUN;
        end
        ST_CASC: begin
          cascade <= wdata;
          st_q    <= need_mode_q ? ST_MODE : ST_RUN;
        end
        ST_MODE: begin
          auto_eoi <= wdata[1];
          st_q     <= ST_RUN;
        end
        default: mask <= wdata;
      endcase
    end else if (sel_cmd) begin
      if (wdata[6]) spec_mask <= wdata[5];
      if (wdata[1]) show_isr  <= wdata[0];
    end
  end
endmodule

// File: rtl/pic8_irr.sv
module pic8_irr #(
  parameter int NUM_IN = 8,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              level_mode,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              take,
  input  logic [IDX_W-1:0]  take_idx,
  output logic [NUM_IN-1:0] irr
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_line
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        irr[i] <= 1'b0;
      end else begin
        prev_q <= irq_in[i];
        if (clr_all)
          irr[i] <= 1'b0;
        else if (take && (take_idx == IDX_W'(i)))
          irr[i] <= 1'b0;
        else if (level_mode)
          irr[i] <= irq_in[i];
        else if (irq_in[i] && !prev_q)
          irr[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic8_resolve.sv
module pic8_resolve #(
  parameter int NUM_IN = 8,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic [NUM_IN-1:0] irr,
  input  logic [NUM_IN-1:0] mask,
  input  logic              spec_mask,
  input  logic              auto_eoi,
  input  logic              vec_ready,
  input  logic              eoi_top,
  input  logic              eoi_sel,
  input  logic [IDX_W-1:0]  eoi_idx,
  output logic [NUM_IN-1:0] isr,
  output logic              offer,
  output logic              take,
  output logic [IDX_W-1:0]  win_idx
);
  logic [NUM_IN-1:0] pend, svc;
  logic              win_hit, svc_hit, top_hit;
  logic [IDX_W-1:0]  svc_idx, top_idx;
  logic [NUM_IN-1:0] clr_vec, set_vec;

  always_comb begin
    pend    = irr & ~mask;
    svc     = spec_mask ? (isr & ~mask) : isr;
    win_hit = 1'b0; win_idx = '0;
    svc_hit = 1'b0; svc_idx = '0;
    top_hit = 1'b0; top_idx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pend[i]) begin win_hit = 1'b1; win_idx = IDX_W'(i); end
      if (svc[i])  begin svc_hit = 1'b1; svc_idx = IDX_W'(i); end
      if (isr[i])  begin top_hit = 1'b1; top_idx = IDX_W'(i); end
    end
    offer   = win_hit && (!svc_hit || (win_idx < svc_idx));
    take    = offer && vec_ready;
    clr_vec = '0;
    if (eoi_top && top_hit) clr_vec = clr_vec | (NUM_IN'(1) << top_idx);
    if (eoi_sel)            clr_vec = clr_vec | (NUM_IN'(1) << eoi_idx);
    set_vec = (take && !auto_eoi) ? (NUM_IN'(1) << win_idx) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       isr <= '0;
    else if (clr_all) isr <= '0;
    else              isr <= (isr & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/pic8_core.sv
module pic8_core #(
  parameter int NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [NUM_IN-1:0] wdata,
  output logic [NUM_IN-1:0] rdata,
  input  logic [NUM_IN-1:0] irq_in,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [NUM_IN-1:0] vec_data,
  output logic [NUM_IN-1:0] cascade_word
);
  localparam int IDX_W = $clog2(NUM_IN);

  logic restart, cfg_run, level_mode, auto_eoi, spec_mask, show_isr;
  logic eoi_top, eoi_sel, take;
  logic [IDX_W-1:0]  eoi_idx, win_idx;
  logic [NUM_IN-1:IDX_W] vec_base;
  logic [NUM_IN-1:0] mask_q, irr_q, isr_q;

  pic8_cfg #(.NUM_IN(NUM_IN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .restart(restart), .cfg_run(cfg_run), .level_mode(level_mode),
    .auto_eoi(auto_eoi), .vec_base(vec_base), .mask(mask_q),
    .cascade(cascade_word), .spec_mask(spec_mask), .show_isr(show_isr),
    .eoi_top(eoi_top), .eoi_sel(eoi_sel), .eoi_idx(eoi_idx)
  );

  pic8_irr #(.NUM_IN(NUM_IN)) u_irr (
    .clk(clk), .rst_n(rst_n), .clr_all(restart), .level_mode(level_mode),
    .irq_in(irq_in), .take(take), .take_idx(win_idx), .irr(irr_q)
  );

  pic8_resolve #(.NUM_IN(NUM_IN)) u_res (
    .clk(clk), .rst_n(rst_n), .clr_all(restart), .irr(irr_q), .mask(mask_q),
    .spec_mask(spec_mask), .auto_eoi(auto_eoi), .vec_ready(vec_ready),
    .eoi_top(eoi_top), .eoi_sel(eoi_sel), .eoi_idx(eoi_idx),
    .isr(isr_q), .offer(vec_valid), .take(take), .win_idx(win_idx)
  );

  always_comb begin
    vec_data = {vec_base, win_idx};
    if (addr)          rdata = mask_q;
    else if (show_isr) rdata = isr_q;
    else               rdata = irr_q;
  end
endmodule

// File: rtl/pic8_chk.sv
module pic8_chk #(
  parameter int NUM_IN = 8,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              addr,
  input logic [NUM_IN-1:0] wdata,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [NUM_IN-1:0] vec_data,
  input logic [NUM_IN-1:0] irr,
  input logic [NUM_IN-1:0] isr,
  input logic [NUM_IN-1:0] mask,
  input logic              auto_eoi,
  input logic              cfg_run
);
  // R6
  offer_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((irr & ~mask) != '0));

  // R9
  take_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready && !auto_eoi && !wr_en) |=> isr[$past(vec_data[IDX_W-1:0])]);

  // R9
  take_clears_irr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> !irr[$past(vec_data[IDX_W-1:0])]);

  // R12
  auto_eoi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready && auto_eoi && !wr_en) |=> (isr == $past(isr)));

  // R2
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (mask == '0 && isr == '0));

  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && cfg_run) |=> (mask == $past(wdata)));
endmodule

bind pic8_core pic8_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
  .irr(irr_q), .isr(isr_q), .mask(mask_q), .auto_eoi(auto_eoi),
  .cfg_run(cfg_run)
);

// File: tb/pic8_core_tb.sv
`timescale 1ns/1ps
module pic8_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irq_in = '0;
  logic       vec_valid;
  logic       vec_ready = 1'b0;
  logic [7:0] vec_data;
  logic [7:0] cascade_word;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pic8_core u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_data(vec_data), .cascade_word(cascade_word)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic take_vec(output logic [7:0] v);
    vec_ready = 1'b1;
    v = vec_data;
    @(negedge clk);
    vec_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b0, d); chk("R1 irr", d, 8'h00);
    rd(1'b1, d); chk("R1 mask", d, 8'h00);
    chk("R1 valid", {7'd0, vec_valid}, 8'h00);
    chk("R1 cascade", cascade_word, 8'h00);
  endtask

  task automatic t_init();
    logic [7:0] d;
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    chk("R3 cascade", cascade_word, 8'h04);
    wr(1'b1, 8'hFF);
    rd(1'b1, d); chk("R3 mask after seq", d, 8'hFF);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_prio();
    logic [7:0] d, v;
    irq_in = 8'h28; step();
    chk("R5 valid", {7'd0, vec_valid}, 8'h01);
    chk("R4 vector", vec_data, 8'h43);
    take_vec(v); chk("R9 taken", v, 8'h43);
    rd(1'b0, d); chk("R9 irr cleared", d, 8'h20);
    chk("R5 blocked by isr", {7'd0, vec_valid}, 8'h00);
    irq_in = 8'h2A; step();
    chk("R5 nest valid", {7'd0, vec_valid}, 8'h01);
    chk("R5 nest vector", vec_data, 8'h41);
    take_vec(v);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R13 isr read", d, 8'h0A);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R10 nonspecific", d, 8'h08);
    wr(1'b0, 8'h63);
    rd(1'b0, d); chk("R11 specific", d, 8'h00);
    chk("R5 pending offered", vec_data, 8'h45);
    take_vec(v);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0A);
    rd(1'b0, d); chk("R7 no relatch while high", d, 8'h00);
    irq_in = 8'h00; step();
  endtask

  task automatic t_mask();
    logic [7:0] d, v;
    wr(1'b1, 8'h01);
    irq_in = 8'h01; step(); irq_in = 8'h00; step();
    rd(1'b0, d); chk("R6 irr visible, R7 held", d, 8'h01);
    chk("R6 masked", {7'd0, vec_valid}, 8'h00);
    wr(1'b1, 8'h00);
    chk("R6 unmasked vector", vec_data, 8'h40);
    chk("R6 unmasked valid", {7'd0, vec_valid}, 8'h01);
    take_vec(v);
    wr(1'b0, 8'h20);
  endtask

  task automatic t_restart();
    logic [7:0] d, v;
    irq_in = 8'h40; step();
    take_vec(v);
    irq_in = 8'h00;
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R13 isr before restart", d, 8'h40);
    wr(1'b0, 8'h1A);
    rd(1'b0, d); chk("R2 read select irr", d, 8'h00);
    rd(1'b1, d); chk("R2 mask cleared", d, 8'h00);
    wr(1'b1, 8'h80);
    wr(1'b1, 8'hF0);
    rd(1'b1, d); chk("R3 short sequence mask", d, 8'hF0);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R2 isr cleared", d, 8'h00);
    wr(1'b0, 8'h0A);
  endtask

  task automatic t_level();
    logic [7:0] d;
    irq_in = 8'h04; step();
    rd(1'b0, d); chk("R8 level high", d, 8'h04);
    chk("R4 level vector", vec_data, 8'h82);
    irq_in = 8'h00; step();
    rd(1'b0, d); chk("R8 level low", d, 8'h00);
    chk("R8 valid drops", {7'd0, vec_valid}, 8'h00);
  endtask

  task automatic t_auto();
    logic [7:0] d, v;
    wr(1'b0, 8'h13); wr(1'b1, 8'h20); wr(1'b1, 8'h03); wr(1'b1, 8'h00);
    irq_in = 8'h10; step();
    take_vec(v); chk("R12 vector", v, 8'h24);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R12 isr untouched", d, 8'h00);
    irq_in = 8'h00; step();
  endtask

  task automatic t_smm();
    logic [7:0] v;
    wr(1'b0, 8'h13); wr(1'b1, 8'h20); wr(1'b1, 8'h01); wr(1'b1, 8'h00);
    irq_in = 8'h04; step();
    take_vec(v);
    irq_in = 8'h24; step();
    chk("R14 blocked normally", {7'd0, vec_valid}, 8'h00);
    wr(1'b1, 8'h04);
    wr(1'b0, 8'h68);
    chk("R14 smm valid", {7'd0, vec_valid}, 8'h01);
    chk("R14 smm vector", vec_data, 8'h25);
    wr(1'b0, 8'h48);
    chk("R14 smm off", {7'd0, vec_valid}, 8'h00);
    irq_in = 8'h00; step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_init();
    t_prio();
    t_mask();
    t_restart();
    t_level();
    t_auto();
    t_smm();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule